// File: doc/BRIEF.md
# Two-Wire Debug Port Escape and Activation Sequencer

This block sits on the host side of a compact two-wire debug link. It wakes a target out of its offline state by driving the link clock (TCKC) and the link data line (TMSC) directly, one phase at a time. It is used whenever the host needs a known link mode: at bring-up, and again after every test-logic reset or TRST-style reset request. Each such request arrives as a one-cycle `start_i` pulse.

A run has four parts. First comes a reset escape: TMSC toggles while TCKC is held high. Then three padding clock pulses follow. Next is a shorter selection escape, also made of toggles under a high clock. Last comes a 12-bit activation packet, sent one bit per clock pulse. The `mode_jscan3_i` input, sampled at start, selects the activation code. One code requests the two-wire scan format. The other requests the classic four-wire scan format, and that one also raises `sel_4wire_o` so an external multiplexer can switch lanes.

Every phase lasts `half_period_i + 1` clock cycles. This value is captured at start, so the link rate can be tuned to the cable and the target without touching the logic.

Top module: `cjtag_activation_seq`

## Requirements
- R1: After reset, and whenever no run is in progress, `tckc_o`, `tmsc_o`, `busy_o`, `done_o` and `sel_4wire_o` are all 0, unless an earlier four-wire run left `sel_4wire_o` at 1.
- R2: A run opens with one phase at TCKC=0, TMSC=0. Then TCKC goes high for 9 phases while TMSC takes 0,1,0,1,0,1,0,1,0. That is 8 toggles while the clock is high, ending at 0. Then TCKC returns low for one phase with TMSC=0.
- R3: Next come three full TCKC pulses, each one high phase followed by one low phase, with TMSC held at 0.
- R4: Next, TCKC is high for 7 phases while TMSC takes 0,1,0,1,0,1,0. That is 6 toggles, ending at 0.
- R5: A 12-bit packet follows, least significant bit first. Each bit is placed on TMSC during a low phase and held through the following high phase, so the target samples it on the TCKC rising edge. A final low phase with TMSC=0 closes the run. In two-wire mode (`mode_jscan3_i`=0) the send order is 0,0,1,1 for the first nibble, 0,0,0,1 for the second and 0,0,0,0 for the third. As a word with bit 0 sent first, this is 12'h08C.
- R6: In four-wire mode (`mode_jscan3_i`=1), only the third bit sent changes, to 0. The packet is then 12'h088.
- R7: Every phase lasts exactly `half_period_i`+1 clock cycles. The value is sampled on the start cycle, and later changes do not affect the run in progress.
- R8: `sel_4wire_o` is 0 from the start cycle through the end of the run. It becomes 1 on the done cycle only for a four-wire run and then holds until the next start.
- R9: `busy_o` is 1 from the cycle after start until the run ends. `done_o` pulses for exactly one cycle, 49·(`half_period_i`+1) cycles after the start edge, as `busy_o` falls.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored: the line waveform, the phase timing and the end time are unchanged.
- R11: A new `start_i` after completion reruns the whole sequence from the baseline. This is the path taken for each reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to run the sequence (reset request) |
| mode_jscan3_i | input | 1 | 1 selects the four-wire activation code, 0 the two-wire code |
| half_period_i | input | DIV_W | Phase length minus one, in clock cycles |
| tckc_o | output | 1 | Link clock toward the target |
| tmsc_o | output | 1 | Link data toward the target |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| sel_4wire_o | output | 1 | Lane select for the external multiplexer, 1 = four-wire |

## Verification
The bench builds the block with its defaults: 8 reset toggles, 3 padding pulses, 6 selection toggles, an 8-bit phase divider and a registered output stage, for a run of 49 phases. Runs use phase lengths of one and three cycles. The one-cycle case places the done pulse right after the last phase, and the three-cycle case shows that timing is held within each phase. Rising-edge capture of the packet and toggle counting under a high clock check the escapes and both activation codes. These checks are independent of the cycle-exact waveform comparison. A start pulse injected mid-run, and back-to-back runs in both modes, reach the ignore rule, the lane-select hand-off and the rerun path.

// File: rtl/cjt_seq_pkg.sv
package cjt_seq_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   typedef struct packed {
      logic clk_ln;
      logic dat_ln;
   } link_pair_t;

   localparam int ACT_BITS = 12;

   // Activation word, bit 0 leaves first: code nibble, extension nibble, check nibble
   function automatic logic [ACT_BITS-1:0] act_word(input logic four_wire);
      logic [3:0] code_nib;
      logic [3:0] ext_nib;
      logic [3:0] chk_nib;
      code_nib = four_wire ? 4'b1000 : 4'b1100;
      ext_nib  = 4'b1000;
      chk_nib  = 4'b0000;
      return {chk_nib, ext_nib, code_nib};
   endfunction

endpackage

// File: rtl/cjt_phase_timer.sv
module cjt_phase_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] limit_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == limit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q <= limit_i));

   // R7
   cnt_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/cjt_step_decode.sv
module cjt_step_decode
   import cjt_seq_pkg::*;
#(
   parameter int RST_TOGGLES = 8,
   parameter int PAD_PULSES  = 3,
   parameter int SEL_TOGGLES = 6,
   parameter int STEP_W      = 6
) (
   input  logic [STEP_W-1:0]   step_i,
   input  logic [ACT_BITS-1:0] word_i,
   output link_pair_t          line_o
);

   localparam int RST_BEG = 1;
   localparam int RST_LEN = RST_TOGGLES + 1;
   localparam int PAD_BEG = RST_BEG + RST_LEN + 1;
   localparam int PAD_LEN = 2 * PAD_PULSES;
   localparam int SEL_BEG = PAD_BEG + PAD_LEN;
   localparam int SEL_LEN = SEL_TOGGLES + 1;
   localparam int PKT_BEG = SEL_BEG + SEL_LEN;
   localparam int PKT_LEN = 2 * ACT_BITS;
   localparam int IDX_W   = $clog2(ACT_BITS);

   logic [STEP_W-1:0] rel_rst;
   logic [STEP_W-1:0] rel_pad;
   logic [STEP_W-1:0] rel_sel;
   logic [STEP_W-1:0] rel_pkt;
   logic [IDX_W-1:0]  bit_idx;
   logic              in_rst, in_pad, in_sel, in_pkt;

   assign rel_rst = step_i - STEP_W'(RST_BEG);
   assign rel_pad = step_i - STEP_W'(PAD_BEG);
   assign rel_sel = step_i - STEP_W'(SEL_BEG);
   assign rel_pkt = step_i - STEP_W'(PKT_BEG);
   assign bit_idx = IDX_W'(rel_pkt >> 1);

   assign in_rst = (step_i >= STEP_W'(RST_BEG)) && (step_i < STEP_W'(RST_BEG + RST_LEN));
   assign in_pad = (step_i >= STEP_W'(PAD_BEG)) && (step_i < STEP_W'(PAD_BEG + PAD_LEN));
   assign in_sel = (step_i >= STEP_W'(SEL_BEG)) && (step_i < STEP_W'(SEL_BEG + SEL_LEN));
   assign in_pkt = (step_i >= STEP_W'(PKT_BEG)) && (step_i < STEP_W'(PKT_BEG + PKT_LEN));

   always_comb begin
      line_o = '0;
      if (in_rst) begin
         line_o.clk_ln = 1'b1;
         line_o.dat_ln = rel_rst[0];
      end else if (in_pad) begin
         line_o.clk_ln = ~rel_pad[0];
         line_o.dat_ln = 1'b0;
      end else if (in_sel) begin
         line_o.clk_ln = 1'b1;
         line_o.dat_ln = rel_sel[0];
      end else if (in_pkt) begin
         line_o.clk_ln = rel_pkt[0];
         line_o.dat_ln = word_i[bit_idx];
      end
   end

endmodule

// File: rtl/cjt_line_drive.sv
module cjt_line_drive
   import cjt_seq_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  link_pair_t line_i,
   output logic       tckc_o,
   output logic       tmsc_o
);

   link_pair_t gated;
   assign gated = en_i ? line_i : '0;

   generate
      if (OUT_REG) begin : g_flop
         link_pair_t line_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= '0;
            else        line_q <= gated;
         end
         assign tckc_o = line_q.clk_ln;
         assign tmsc_o = line_q.dat_ln;

         // R1
         idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(en_i) |-> (!tckc_o && !tmsc_o));
      end else begin : g_wire
         assign tckc_o = gated.clk_ln;
         assign tmsc_o = gated.dat_ln;
      end
   endgenerate

endmodule

// File: rtl/cjtag_activation_seq.sv
module cjtag_activation_seq
   import cjt_seq_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int RST_TOGGLES = 8,
   parameter int PAD_PULSES  = 3,
   parameter int SEL_TOGGLES = 6,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             mode_jscan3_i,
   input  logic [DIV_W-1:0] half_period_i,
   output logic             tckc_o,
   output logic             tmsc_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             sel_4wire_o
);

   localparam int NSTEPS = 1 + (RST_TOGGLES + 1) + 1 + 2 * PAD_PULSES
                         + (SEL_TOGGLES + 1) + 2 * ACT_BITS + 1;
   localparam int LAST   = NSTEPS - 1;
   localparam int STEP_W = $clog2(NSTEPS);

   generate
      if (RST_TOGGLES < 2 || (RST_TOGGLES % 2) != 0) begin : g_bad_rst
         $error("RST_TOGGLES must be even and at least 2");
      end
      if (SEL_TOGGLES < 2 || (SEL_TOGGLES % 2) != 0) begin : g_bad_sel
         $error("SEL_TOGGLES must be even and at least 2");
      end
      if (PAD_PULSES < 1) begin : g_bad_pad
         $error("PAD_PULSES must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   seq_state_e        st_q;
   logic [STEP_W-1:0] step_q;
   logic [DIV_W-1:0]  div_q;
   logic              mode_q;
   logic              done_q;
   logic              sel_q;
   logic              tick;
   logic              busy;
   link_pair_t        line;

   assign busy = (st_q == SEQ_RUN);

   cjt_phase_timer #(.DIV_W(DIV_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (busy),
      .limit_i (div_q),
      .tick_o  (tick)
   );

   cjt_step_decode #(
      .RST_TOGGLES (RST_TOGGLES),
      .PAD_PULSES  (PAD_PULSES),
      .SEL_TOGGLES (SEL_TOGGLES),
      .STEP_W      (STEP_W)
   ) u_decode (
      .step_i (step_q),
      .word_i (act_word(mode_q)),
      .line_o (line)
   );

   cjt_line_drive #(.OUT_REG(OUT_REG)) u_drive (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (busy),
      .line_i (line),
      .tckc_o (tckc_o),
      .tmsc_o (tmsc_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         step_q <= '0;
         div_q  <= '0;
         mode_q <= 1'b0;
         done_q <= 1'b0;
         sel_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            SEQ_IDLE: begin
               if (start_i) begin
                  st_q   <= SEQ_RUN;
                  step_q <= '0;
                  div_q  <= half_period_i;
                  mode_q <= mode_jscan3_i;
                  sel_q  <= 1'b0;
               end
            end
            SEQ_RUN: begin
               if (tick) begin
                  if (step_q == STEP_W'(LAST)) begin
                     st_q   <= SEQ_IDLE;
                     done_q <= 1'b1;
                     sel_q  <= mode_q;
                  end else begin
                     step_q <= step_q + 1'b1;
                  end
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy_o      = busy;
   assign done_o      = done_q;
   assign sel_4wire_o = sel_q;

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   // R8
   sel_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !sel_4wire_o);

   // R10
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !tick) |=> (step_q == $past(step_q)));

   // R7
   setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(mode_q) && $stable(div_q)));

   // R11
   step_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> (step_q >= $past(step_q)));

endmodule

// File: tb/cjtag_activation_seq_tb.sv
module cjtag_activation_seq_tb;

   localparam int NPH = 49;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       mode_jscan3_i = 1'b0;
   logic [7:0] half_period_i = 8'd0;
   logic       tckc_o, tmsc_o, busy_o, done_o, sel_4wire_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cjtag_activation_seq u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .mode_jscan3_i (mode_jscan3_i),
      .half_period_i (half_period_i),
      .tckc_o        (tckc_o),
      .tmsc_o        (tmsc_o),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .sel_4wire_o   (sel_4wire_o)
   );

   task automatic check(input string req, input bit ok, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Expected phase waveform from the requirements, {clock, data}
   function automatic logic [1:0] exp_phase(input int k, input bit fw);
      logic [11:0] word;
      word = fw ? 12'h088 : 12'h08C;
      if (k == 0)                return 2'b00;
      if (k >= 1 && k <= 9)      return {1'b1, ((k - 1) % 2 == 1)};      // R2
      if (k == 10)               return 2'b00;
      if (k >= 11 && k <= 16)    return {((k - 11) % 2 == 0), 1'b0};    // R3
      if (k >= 17 && k <= 23)    return {1'b1, ((k - 17) % 2 == 1)};    // R4
      if (k >= 24 && k <= 47)    return {((k - 24) % 2 == 1), word[(k - 24) / 2]}; // R5 R6
      return 2'b00;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1 idle lines", {tckc_o, tmsc_o, busy_o, done_o, sel_4wire_o} == 5'b0,
            {tckc_o, tmsc_o, busy_o, done_o, sel_4wire_o}, 0);
   endtask

   task automatic run_seq(input bit fw, input int hp, input bit poke_start, input bit tweak_hp);
      int d, total, rises, tg_rst, tg_sel, wave_bad;
      logic [11:0] got_word;
      logic prev_c, prev_d;
      d = hp + 1;
      total = NPH * d;
      rises = 0; tg_rst = 0; tg_sel = 0; wave_bad = 0; got_word = '0;
      prev_c = 1'b0; prev_d = 1'b0;
      @(negedge clk);
      mode_jscan3_i = fw;
      half_period_i = 8'(hp);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (tweak_hp) half_period_i = 8'(hp + 5);
      mode_jscan3_i = ~fw;
      // R8
      check("R8 select cleared on start", sel_4wire_o == 1'b0, sel_4wire_o, 0);
      check("R9 busy after start", busy_o == 1'b1, busy_o, 1);
      for (int n = 1; n <= total; n++) begin
         logic [1:0] e;
         if (poke_start && n == 7) start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         e = exp_phase((n - 1) / d, fw);
         if ({tckc_o, tmsc_o} != e) begin
            wave_bad++;
            if (wave_bad == 1)
               check("R2-phase waveform R7 R10", 1'b0, {tckc_o, tmsc_o}, e);
         end
         if (tckc_o && !prev_c) begin
            rises++;
            if (rises >= 6 && rises <= 17) got_word[rises - 6] = tmsc_o;
         end
         if (tckc_o && prev_c && (tmsc_o != prev_d)) begin
            if (rises == 1) tg_rst++;
            if (rises == 5) tg_sel++;
         end
         prev_c = tckc_o; prev_d = tmsc_o;
         if (n < total) begin
            if (!busy_o || done_o || sel_4wire_o) begin
               wave_bad++;
               if (wave_bad == 1)
                  check("R9 busy/done/R8 select during run", 1'b0,
                        {busy_o, done_o, sel_4wire_o}, 3'b100);
            end
         end else begin
            check("R9 done at end", done_o == 1'b1 && busy_o == 1'b0, {done_o, busy_o}, 2'b10);
            check("R8 select at end", sel_4wire_o == fw, sel_4wire_o, fw);
         end
      end
      check("R7 R10 waveform clean", wave_bad == 0, wave_bad, 0);
      check("R2 reset escape toggles", tg_rst == 8, tg_rst, 8);
      check("R4 select escape toggles", tg_sel == 6, tg_sel, 6);
      check("R3 clock rises", rises == 17, rises, 17);
      if (fw) check("R6 packet", got_word == 12'h088, got_word, 12'h088);
      else    check("R5 packet", got_word == 12'h08C, got_word, 12'h08C);
      @(negedge clk);
      check("R9 done one cycle", done_o == 1'b0, done_o, 0);
      check("R1 idle after run", {tckc_o, tmsc_o, busy_o} == 3'b0, {tckc_o, tmsc_o, busy_o}, 0);
      check("R8 select held", sel_4wire_o == fw, sel_4wire_o, fw);
   endtask

   task automatic test_two_wire_fast();
      run_seq(1'b0, 0, 1'b0, 1'b0);
   endtask

   task automatic test_four_wire_slow();
      run_seq(1'b1, 2, 1'b0, 1'b1);
   endtask

   task automatic test_start_while_busy();
      // R10
      run_seq(1'b0, 1, 1'b1, 1'b0);
   endtask

   task automatic test_rerun();
      // R11
      run_seq(1'b1, 0, 1'b0, 1'b0);
      run_seq(1'b0, 0, 1'b0, 1'b0);
      check("R11 two-wire rerun leaves select low", sel_4wire_o == 1'b0, sel_4wire_o, 0);
   endtask

   initial begin
      do_reset();
      test_two_wire_fast();
      test_four_wire_slow();
      test_start_while_busy();
      test_rerun();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule